// File: doc/BRIEF.md
# Sixteen-Line Edge-Interrupt GPIO Port

This block is a general-purpose I/O port of sixteen lines behind a small memory-mapped register slot. Software sets the direction of each line and the value that output lines drive. It reads back the synchronized pin levels through a per-line enable. Any line set as an input can raise a status bit when it sees an edge. A per-line select picks whether that edge is rising or falling.

Status bits are sticky. A single interrupt request is the OR of all of them. Software clears status by writing ones. Each pin input passes through a two-flop synchronizer. An edge is found by comparing the synchronized level with its value one cycle earlier. The register slot is 32 bits wide. Only the low sixteen bits carry data.

Top module: `gpio16_edge_port`

## Requirements
- R1: After reset, the output-data, direction, edge-select, mask and pin-enable registers read 0xFFFF. Status reads 0, `irq` is 0 and `pin_oe` is 0.
- R2: A direction bit of 1 makes a line an input and `pin_oe` low. A direction bit of 0 gives `pin_oe` high and puts the output-data bit on `pin_out`. `pin_out` is 0 on input lines.
- R3: A read at offset 0x00 returns the synchronized pin levels ANDed with the pin-enable register (offset 0x18). A pin change shows there after the second rising clock edge.
- R4: On an input line, an edge-select bit of 1 (offset 0x0C) latches a status bit on a rising edge. A bit of 0 latches it on a falling edge. The edge of the other polarity has no effect.
- R5: An edge sets a status bit only when the line's direction bit is 1 and its mask bit (offset 0x10) is 0.
- R6: Status bits (offset 0x14) stay set until a write puts a 1 in that bit position. `irq` is high exactly while any status bit is set, so it stays high until every set bit has been cleared.
- R7: When a clear of a status bit and a new qualifying edge on the same line fall in the same clock cycle, the bit stays set.
- R8: Writes to offset 0x00 and to undefined or unaligned offsets change no register. Reads of undefined offsets return 0. Bits 31:16 of write data are ignored and read as 0.
- R9: A pin change that qualifies sets status and raises `irq` on the third rising clock edge after the change: two synchronizer edges and one status edge.
- R10: Output data (0x04), direction (0x08), edge select, mask and pin enable read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data; low 16 bits used |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Driven output levels |
| pin_oe | output | 16 | Per-line output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
A corrupted status register shows up at `irq` in the very cycle it goes wrong. It also shows at the status read on the next access, because `irq` is decoded straight from the status flops. A wrong synchronizer or previous-level flop appears as a spurious or missing status bit three edges after a pin change. It also appears in the data-input read two edges after the change. The bench drives random configurations and pin patterns, holds each pin pattern long enough to settle, and compares status, `irq` and the readbacks with values it derives itself. Directed cases pin down the exact latency and the case where a clear and an edge arrive together.

// File: rtl/gpio16_pkg.sv
// Package: register offsets and shared constants for the 16-line GPIO port.
// Assumes byte addressing with one 32-bit slot per register.
package gpio16_pkg;
    localparam int GP_ADDR_W = 8;

    typedef enum logic [GP_ADDR_W-1:0] {
        OFS_DIN  = 8'h00,
        OFS_DOUT = 8'h04,
        OFS_DIR  = 8'h08,
        OFS_EDGE = 8'h0C,
        OFS_MASK = 8'h10,
        OFS_STAT = 8'h14,
        OFS_PEN  = 8'h18
    } gp_ofs_e;
endpackage

// File: rtl/gpio16_sync.sv
// Module: multi-stage pin synchronizer that also keeps the previous
// synchronized level, so edges can be found downstream.
// Assumes STAGES >= 2; all flops reset to zero.
module gpio16_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_now,
    output logic [W-1:0] pin_last
);
    logic [STAGES-1:0][W-1:0] stg_q;
    logic [W-1:0]             last_q;

    // Shift raw pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= pin_raw;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    // Keep the synchronized level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= stg_q[STAGES-1];
    end

    assign pin_now  = stg_q[STAGES-1];
    assign pin_last = last_q;
endmodule

// File: rtl/gpio16_regs.sv
// Module: register file and address decode. It holds output data,
// direction, edge select, mask and pin enable, and generates the
// status write-one-to-clear strobe. Reads are combinational on address.
// Assumes DW > W; only offsets in gpio16_pkg are defined.
module gpio16_regs
    import gpio16_pkg::*;
#(
    parameter int W  = 16,
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [GP_ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [W-1:0]         pin_now,
    input  logic [W-1:0]         stat,
    output logic [W-1:0]         dout,
    output logic [W-1:0]         dir,
    output logic [W-1:0]         edge_sel,
    output logic [W-1:0]         mask,
    output logic [W-1:0]         pen,
    output logic                 clr_en,
    output logic [W-1:0]         clr_bits
);
    localparam int PAD = DW - W;

    logic         wr;
    logic [W-1:0] wval;
    logic [W-1:0] rval;
    logic         unused_hi;

    assign wr        = bus_sel & bus_we;
    assign wval      = bus_wdata[W-1:0];
    assign unused_hi = ^bus_wdata[DW-1:W];
    assign clr_en    = wr && (bus_addr == OFS_STAT);
    assign clr_bits  = wval;

    // Update the writable configuration registers on a decoded write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout     <= '1;
            dir      <= '1;
            edge_sel <= '1;
            mask     <= '1;
            pen      <= '1;
        end else if (wr) begin
            case (bus_addr)
                OFS_DOUT: dout     <= wval;
                OFS_DIR:  dir      <= wval;
                OFS_EDGE: edge_sel <= wval;
                OFS_MASK: mask     <= wval;
                OFS_PEN:  pen      <= wval;
                default:  ;
            endcase
        end
    end

    // Select the read value for the current offset.
    always_comb begin
        case (bus_addr)
            OFS_DIN:  rval = pin_now & pen;
            OFS_DOUT: rval = dout;
            OFS_DIR:  rval = dir;
            OFS_EDGE: rval = edge_sel;
            OFS_MASK: rval = mask;
            OFS_STAT: rval = stat;
            OFS_PEN:  rval = pen;
            default:  rval = '0;
        endcase
    end

    assign bus_rdata = {{PAD{1'b0}}, rval};

    // R8: a write to the read-only or an undefined offset leaves all config unchanged
    a_r8_ignored_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !(bus_addr inside {OFS_DOUT, OFS_DIR, OFS_EDGE, OFS_MASK, OFS_PEN}))
        |=> ($stable(dout) && $stable(dir) && $stable(edge_sel)
             && $stable(mask) && $stable(pen)));
endmodule

// File: rtl/gpio16_evt.sv
// Module: per-line edge qualification and the sticky status register.
// A qualifying edge wins over a same-cycle clear. irq is the OR of status.
// Assumes pin_now/pin_last come from the synchronizer.
module gpio16_evt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_now,
    input  logic [W-1:0] pin_last,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] mask,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] stat,
    output logic         irq
);
    logic [W-1:0] hit;
    logic [W-1:0] clr_eff;

    // One qualifier per line: polarity select, input direction, unmasked.
    for (genvar i = 0; i < W; i++) begin : g_line
        logic rise_i, fall_i;
        assign rise_i = pin_now[i] & ~pin_last[i];
        assign fall_i = ~pin_now[i] & pin_last[i];
        assign hit[i] = dir[i] & ~mask[i] & (edge_sel[i] ? rise_i : fall_i);
    end

    assign clr_eff = clr_en ? clr_bits : '0;

    // Sticky status: clear requested bits, then set new hits on top.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr_eff) | hit;
    end

    assign irq = |stat;

    // R5: a newly set status bit needs an input-configured, unmasked line
    a_r5_qualified_only: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~$past(stat) & ($past(mask) | ~$past(dir))) == '0));

    // R4: a newly set status bit needs a level change on that line
    a_r4_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~$past(stat) & ~($past(pin_now) ^ $past(pin_last))) == '0));

    // R6: with no clear, the request cannot drop
    a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_en) |=> irq);

    // R7: a hit coinciding with its clear leaves the bit set
    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit & clr_eff) != '0) |=> ((stat & $past(hit & clr_eff)) == $past(hit & clr_eff)));

    // R6: a cleared bit with no coinciding hit reads zero next cycle
    a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> ((stat & $past(clr_bits & ~hit)) == '0));
endmodule

// File: rtl/gpio16_edge_port.sv
// Module: top of the 16-line GPIO port. It ties together the synchronizer,
// the register file and the edge/status logic, and drives pin outputs.
// Assumes a single clock and synchronous active-low reset.
module gpio16_edge_port
    import gpio16_pkg::*;
#(
    parameter int W      = 16,
    parameter int DW     = 32,
    parameter int STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [GP_ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [W-1:0]         pin_in,
    output logic [W-1:0]         pin_out,
    output logic [W-1:0]         pin_oe,
    output logic                 irq
);
    logic [W-1:0] pin_now, pin_last;
    logic [W-1:0] dout, dir, edge_sel, mask, pen, stat, clr_bits;
    logic         clr_en;

    gpio16_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_in),
        .pin_now(pin_now), .pin_last(pin_last)
    );

    gpio16_regs #(.W(W), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_now(pin_now), .stat(stat),
        .dout(dout), .dir(dir), .edge_sel(edge_sel), .mask(mask), .pen(pen),
        .clr_en(clr_en), .clr_bits(clr_bits)
    );

    gpio16_evt #(.W(W)) u_evt (
        .clk(clk), .rst_n(rst_n),
        .pin_now(pin_now), .pin_last(pin_last),
        .dir(dir), .edge_sel(edge_sel), .mask(mask),
        .clr_en(clr_en), .clr_bits(clr_bits),
        .stat(stat), .irq(irq)
    );

    // Output lines drive their data; input lines are released.
    assign pin_oe  = ~dir;
    assign pin_out = dout & ~dir;
endmodule

// File: tb/gpio16_edge_port_test.sv
module gpio16_edge_port_test;
    localparam logic [7:0] A_DIN = 8'h00, A_DOUT = 8'h04, A_DIR = 8'h08,
                           A_EDGE = 8'h0C, A_MASK = 8'h10, A_STAT = 8'h14,
                           A_PEN = 8'h18;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_sel = 0, bus_we = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = 0;
    logic [15:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0, fails = 0;
    logic [15:0] pins = 0;
    logic [15:0] exp_stat = 0;

    always #2.5 clk = ~clk;

    gpio16_edge_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0; bus_addr = A_DIN; bus_wdata = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 0; bus_addr = A_DIN;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic set_pins(input logic [15:0] p);
        @(negedge clk);
        pin_in = p; pins = p;
    endtask

    function automatic logic [15:0] edge_hits(input logic [15:0] oldp, newp,
                                              dir, edg, msk);
        return dir & ~msk & ((edg & newp & ~oldp) | (~edg & ~newp & oldp));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset values
        rchk("R1 dout", A_DOUT, 32'hFFFF);
        rchk("R1 dir", A_DIR, 32'hFFFF);
        rchk("R1 edge", A_EDGE, 32'hFFFF);
        rchk("R1 mask", A_MASK, 32'hFFFF);
        rchk("R1 pen", A_PEN, 32'hFFFF);
        rchk("R1 stat", A_STAT, 32'h0);
        rchk("R1 din", A_DIN, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 pin_oe", {16'b0, pin_oe}, 32'h0);

        // R9: exact latency of a rising edge on line 0
        wr(A_MASK, 32'h0);
        set_pins(16'h0001);
        @(negedge clk); #1 chk("R3 din after 1 edge", bus_rdata, 32'h0);
        @(negedge clk); #1 chk("R9 irq after 2 edges", {31'b0, irq}, 32'h0);
        chk("R3 din after 2 edges", bus_rdata, 32'h1);
        @(negedge clk); #1 chk("R9 irq after 3 edges", {31'b0, irq}, 32'h1);
        repeat (5) @(negedge clk);
        chk("R6 sticky irq", {31'b0, irq}, 32'h1);
        wr(A_STAT, 32'h1);
        chk("R6 irq drops", {31'b0, irq}, 32'h0);

        // R6: partial clear keeps irq
        set_pins(16'h0007);
        repeat (4) @(negedge clk);
        rchk("R4 two rises", A_STAT, 32'h6);
        wr(A_STAT, 32'h2);
        chk("R6 irq stays", {31'b0, irq}, 32'h1);
        rchk("R6 partial clear", A_STAT, 32'h4);
        wr(A_STAT, 32'h4);
        chk("R6 irq all clear", {31'b0, irq}, 32'h0);

        // R4: falling select on line 3
        wr(A_EDGE, 32'hFFF7);
        set_pins(16'h000F);
        repeat (4) @(negedge clk);
        rchk("R4 rise ignored on falling line", A_STAT, 32'h0);
        set_pins(16'h0007);
        repeat (4) @(negedge clk);
        rchk("R4 fall detected", A_STAT, 32'h8);
        wr(A_STAT, 32'hFFFF);

        // R7: clear lands in the same cycle as a new hit on line 4
        set_pins(16'h0017);
        @(negedge clk);
        wr(A_STAT, 32'h10);
        rchk("R7 event wins", A_STAT, 32'h10);
        // Control: clear one cycle later removes it
        wr(A_STAT, 32'h10);
        rchk("R7 later clear", A_STAT, 32'h0);

        // R8: ignored writes, undefined reads, upper bits
        wr(A_DOUT, 32'hABCD_1234);
        rchk("R8 upper wdata ignored", A_DOUT, 32'h0000_1234);
        wr(A_DIN, 32'h0000_5555);
        wr(8'h1C, 32'h0000_0000);
        wr(8'h05, 32'h0000_0000);
        rchk("R8 dout unchanged", A_DOUT, 32'h1234);
        rchk("R8 dir unchanged", A_DIR, 32'hFFFF);
        rchk("R8 edge unchanged", A_EDGE, 32'hFFF7);
        rchk("R8 mask unchanged", A_MASK, 32'h0);
        rchk("R8 pen unchanged", A_PEN, 32'hFFFF);
        rchk("R8 din read-only", A_DIN, {16'b0, pins});
        rchk("R8 undefined 0x1C", 8'h1C, 32'h0);
        rchk("R8 undefined 0x40", 8'h40, 32'h0);

        // Quiet state for the random phase
        wr(A_MASK, 32'hFFFF);
        set_pins(16'h0);
        repeat (4) @(negedge clk);
        wr(A_STAT, 32'hFFFF);
        exp_stat = 0;

        for (int it = 0; it < 60; it++) begin
            logic [15:0] d_dir, d_edg, d_msk, d_pen, d_out, newp, clr;
            d_dir = 16'($urandom); d_edg = 16'($urandom);
            d_msk = 16'($urandom); d_pen = 16'($urandom);
            d_out = 16'($urandom);
            wr(A_DIR, {16'($urandom), d_dir});
            wr(A_EDGE, {16'b0, d_edg});
            wr(A_MASK, {16'b0, d_msk});
            wr(A_PEN, {16'b0, d_pen});
            wr(A_DOUT, {16'b0, d_out});
            rchk("R10 dir readback", A_DIR, {16'b0, d_dir});
            rchk("R10 edge readback", A_EDGE, {16'b0, d_edg});
            rchk("R10 mask readback", A_MASK, {16'b0, d_msk});
            rchk("R10 pen readback", A_PEN, {16'b0, d_pen});
            chk("R2 pin_oe", {16'b0, pin_oe}, {16'b0, ~d_dir});
            chk("R2 pin_out", {16'b0, pin_out}, {16'b0, d_out & ~d_dir});

            newp = 16'($urandom);
            exp_stat = exp_stat | edge_hits(pins, newp, d_dir, d_edg, d_msk);
            set_pins(newp);
            repeat (4) @(negedge clk);
            rchk("R3 din gated", A_DIN, {16'b0, newp & d_pen});
            rchk("R5 status", A_STAT, {16'b0, exp_stat});
            chk("R6 irq", {31'b0, irq}, {31'b0, exp_stat != 0});

            clr = 16'($urandom);
            wr(A_STAT, {16'($urandom), clr});
            exp_stat = exp_stat & ~clr;
            rchk("R6 status after clear", A_STAT, {16'b0, exp_stat});
            chk("R6 irq after clear", {31'b0, irq}, {31'b0, exp_stat != 0});
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule